// File: doc/BRIEF.md
# Reset Sequencing Controller

This controller merges every reset request a small microcontroller core can see: the power-on event, an active-low external reset pin, a watchdog timeout and a brown-out detect pulse. When any of them fires it drives the chip-reset output high. It then releases that output only after a power-up delay and an oscillator start-up delay have both run out. Each delay can be switched off by a configuration input. Supply-level detection is analog and sits outside the block, so the power-on event arrives as an asynchronous active-low input and the brown-out event as a one-cycle pulse.

The block also records why the last reset happened. A timeout flag, a power-down flag, a brown-out flag and a three-bit cause code let firmware tell the events apart. A watchdog timeout while the core sleeps does not reset the chip: it raises a one-cycle wake pulse and updates the flags.

The whole block runs on the main oscillator clock. The power-up delay counter advances only on strobes from the slow internal tick, so it measures slow-clock periods. The external pin passes through a two-stage synchronizer and then a glitch filter before it is accepted.

Top module: `rst_seq`

## Requirements
- R1: While `por_n` is low, the outputs are `chip_rst`=1, `flag_to`=1, `flag_pd`=1, `flag_bor`=0, `cause`=0 and `wake`=0.
- R2: After any reset event, `chip_rst` stays high for one hold cycle, then for 2^PWRT_W power-up ticks, then for 2^OST_W clock cycles. With `lf_tick` held high this is 1+2^PWRT_W+2^OST_W cycles. The same length applies from the release of `por_n`, counted from the clock cycle in which it is released.
- R3: The power-up delay advances only in cycles where `lf_tick` is 1. If no tick arrives, the chip stays in reset.
- R4: `cfg_pwrt_en`=0 skips the power-up delay and `cfg_ost_en`=0 skips the oscillator delay. With both at 0, `chip_rst` is high for exactly the single hold cycle.
- R5: `ext_rst_n` is synchronized through two flops. It is accepted only after FILT_LEN consecutive low samples, so a shorter pulse leaves the chip running and the flags unchanged. While the pin stays low, `chip_rst` stays high; the delay sequence starts once the pin returns high.
- R6: A `bod_det` pulse counts only while `cfg_bod_en` or `sw_bod_en` is 1. When it counts, it restarts the full delay sequence, even in mid-sequence, and sets `flag_bor`=1, `flag_to`=1, `flag_pd`=1 and `cause`=3.
- R7: A `wdt_to` pulse while not sleeping and not in reset asserts `chip_rst`, sets `flag_to`=0, leaves `flag_pd` unchanged and sets `cause`=1. While `chip_rst` is high, `wdt_to` has no effect.
- R8: A `wdt_to` pulse while `sleeping`=1 does not assert `chip_rst`. Instead it gives a one-cycle `wake` pulse and sets `flag_to`=0, `flag_pd`=0 and `cause`=2.
- R9: An accepted external reset while running leaves `flag_to` and `flag_pd` unchanged and sets `cause`=4. An accepted external reset while sleeping sets `flag_pd`=0, leaves `flag_to` unchanged and sets `cause`=5.
- R10: When events arrive in the same cycle, brown-out wins over an external reset, which wins over a watchdog. `cause` only ever takes the values 0 to 5.
- R11: A power-on event clears `flag_bor` back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Power-on event, asynchronous, active low |
| lf_tick | input | 1 | One-cycle strobe from the slow internal oscillator |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_to | input | 1 | Watchdog timeout pulse |
| bod_det | input | 1 | Brown-out detect pulse |
| sleeping | input | 1 | Core is in sleep |
| cfg_pwrt_en | input | 1 | Enable power-up delay |
| cfg_ost_en | input | 1 | Enable oscillator start-up delay |
| cfg_bod_en | input | 1 | Brown-out enable from configuration |
| sw_bod_en | input | 1 | Brown-out enable from software |
| chip_rst | output | 1 | Chip reset, active high |
| wake | output | 1 | One-cycle wake-up from sleep by the watchdog |
| flag_to | output | 1 | Timeout flag; 0 after a watchdog event |
| flag_pd | output | 1 | Power-down flag; 0 after an event in sleep |
| flag_bor | output | 1 | Set by an accepted brown-out |
| cause | output | 3 | Last event: 0 power-on, 1 watchdog run, 2 watchdog sleep, 3 brown-out, 4 pin run, 5 pin sleep |

## Verification
The bench builds the controller with PWRT_W=4, OST_W=3 and FILT_LEN=4. A full release then takes 25 cycles, so each event kind can be run from a fresh power-on many times. The short delays also let the bench measure exact release lengths for every combination of delay enables, a stalled tick, a restart in mid-sequence and a pin held low. Because the filter keeps its default length, the bench tests the boundary where a three-sample pulse is rejected and a four-sample pulse is accepted.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int PWRT_W   = 11,
  parameter int OST_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lf_tick,
  input  logic       ext_rst_n,
  input  logic       wdt_to,
  input  logic       bod_det,
  input  logic       sleeping,
  input  logic       cfg_pwrt_en,
  input  logic       cfg_ost_en,
  input  logic       cfg_bod_en,
  input  logic       sw_bod_en,
  output logic       chip_rst,
  output logic       wake,
  output logic       flag_to,
  output logic       flag_pd,
  output logic       flag_bor,
  output logic [2:0] cause
);
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [1:0] {S_HOLD, S_PWRT, S_OST, S_RUN} phase_t;

  phase_t            phase;
  logic              sync1, sync2;
  logic [FW-1:0]     fcnt;
  logic [PWRT_W-1:0] pw_cnt;
  logic [OST_W-1:0]  ost_cnt;

  wire ext_acc = !sync2 && (fcnt == FW'(FILT_LEN - 1));
  wire ext_low = (fcnt == FW'(FILT_LEN));
  wire bod_on  = bod_det && (cfg_bod_en || sw_bod_en);
  wire wdt_run = wdt_to && !sleeping && !chip_rst;
  wire wdt_slp = wdt_to && sleeping && !chip_rst;
  wire any_rst = bod_on || ext_acc || wdt_run;

  assign chip_rst = (phase != S_RUN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      fcnt  <= '0;
    end else begin
      sync1 <= ext_rst_n;
      sync2 <= sync1;
      if (sync2)        fcnt <= '0;
      else if (!ext_low) fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase   <= S_HOLD;
      pw_cnt  <= '0;
      ost_cnt <= '0;
    end else if (any_rst || ext_low) begin
      phase   <= S_HOLD;
      pw_cnt  <= '0;
      ost_cnt <= '0;
    end else begin
      case (phase)
        S_HOLD: begin
          if (cfg_pwrt_en)     phase <= S_PWRT;
          else if (cfg_ost_en) phase <= S_OST;
          else                 phase <= S_RUN;
        end
        S_PWRT: if (lf_tick) begin
          if (&pw_cnt) begin
            pw_cnt <= '0;
            phase  <= cfg_ost_en ? S_OST : S_RUN;
          end else begin
            pw_cnt <= pw_cnt + 1'b1;
          end
        end
        S_OST: begin
          if (&ost_cnt) begin
            ost_cnt <= '0;
            phase   <= S_RUN;
          end else begin
            ost_cnt <= ost_cnt + 1'b1;
          end
        end
        default: phase <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_to  <= 1'b1;
      flag_pd  <= 1'b1;
      flag_bor <= 1'b0;
      cause    <= 3'd0;
      wake     <= 1'b0;
    end else begin
      wake <= 1'b0;
      if (bod_on) begin
        flag_to  <= 1'b1;
        flag_pd  <= 1'b1;
        flag_bor <= 1'b1;
        cause    <= 3'd3;
      end else if (ext_acc) begin
        if (sleeping) flag_pd <= 1'b0;
        cause <= sleeping ? 3'd5 : 3'd4;
      end else if (wdt_run) begin
        flag_to <= 1'b0;
        cause   <= 3'd1;
      end else if (wdt_slp) begin
        flag_to <= 1'b0;
        flag_pd <= 1'b0;
        cause   <= 3'd2;
        wake    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wdt_to,
  input logic       bod_det,
  input logic       sleeping,
  input logic       cfg_bod_en,
  input logic       sw_bod_en,
  input logic       chip_rst,
  input logic       wake,
  input logic       flag_to,
  input logic       flag_pd,
  input logic       flag_bor,
  input logic [2:0] cause
);
  a_r8_wake_no_reset: assert property (@(posedge clk) disable iff (!por_n)
    wake |-> !chip_rst && !flag_to && !flag_pd && cause == 3'd2);

  a_r6_bod_restart: assert property (@(posedge clk) disable iff (!por_n)
    (bod_det && (cfg_bod_en || sw_bod_en)) |=> chip_rst && flag_bor && flag_to && flag_pd && cause == 3'd3);

  a_r7_wdt_run_reset: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_to && !sleeping && !chip_rst && !bod_det) |=> chip_rst);

  a_r8_wdt_sleep_no_reset: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_to && sleeping && !chip_rst && !bod_det && !$past(chip_rst)) |=> wake || chip_rst);

  a_r10_cause_legal: assert property (@(posedge clk) disable iff (!por_n)
    cause <= 3'd5);

  a_r6_bor_only_by_bod: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_bor) |-> chip_rst && cause == 3'd3);
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .wdt_to(wdt_to), .bod_det(bod_det),
  .sleeping(sleeping), .cfg_bod_en(cfg_bod_en), .sw_bod_en(sw_bod_en),
  .chip_rst(chip_rst), .wake(wake), .flag_to(flag_to), .flag_pd(flag_pd),
  .flag_bor(flag_bor), .cause(cause)
);

// File: tb/rst_seq_test.sv
`timescale 1ns/1ps
module rst_seq_test;
  logic clk = 0, por_n = 0, lf_tick = 1, ext_n = 1, wdt = 0, bod = 0, slp = 0;
  logic pw_en = 1, ost_en = 1, bcfg = 1, bsw = 0;
  logic chip_rst, wake, flag_to, flag_pd, flag_bor;
  logic [2:0] cause;
  int errors = 0, checks = 0, n;
  logic saw_rst = 0, saw_wake = 0;

  rst_seq #(.PWRT_W(4), .OST_W(3), .FILT_LEN(4)) uut (
    .clk(clk), .por_n(por_n), .lf_tick(lf_tick), .ext_rst_n(ext_n),
    .wdt_to(wdt), .bod_det(bod), .sleeping(slp), .cfg_pwrt_en(pw_en),
    .cfg_ost_en(ost_en), .cfg_bod_en(bcfg), .sw_bod_en(bsw),
    .chip_rst(chip_rst), .wake(wake), .flag_to(flag_to), .flag_pd(flag_pd),
    .flag_bor(flag_bor), .cause(cause));

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    if (chip_rst) saw_rst = 1;
    if (wake) saw_wake = 1;
  end

  // fields: prep, kind(0 wdt,1 bod,2 pin), sleep, bod_en, rst, to, pd, cause, bor
  localparam logic [11:0] VEC [8] = '{
    12'b0_00_0_1_1_0_1_001_0,
    12'b0_00_1_1_0_0_0_010_0,
    12'b1_01_0_1_1_1_1_011_1,
    12'b1_10_0_1_1_0_0_100_0,
    12'b0_10_0_1_1_1_1_100_0,
    12'b0_10_1_1_1_1_0_101_0,
    12'b1_10_1_1_1_0_0_101_0,
    12'b0_01_0_0_0_1_1_000_0
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic count_rst(output int c);
    c = 0;
    while (chip_rst && c < 5000) begin c++; @(negedge clk); end
  endtask

  task automatic do_por();
    por_n = 0; step(2); por_n = 1; count_rst(n);
  endtask

  task automatic pulse_bod();
    bod = 1; step(1); bod = 0;
  endtask

  task automatic pulse_wdt();
    wdt = 1; step(1); wdt = 0;
  endtask

  task automatic pin_low(int k);
    ext_n = 0; step(k); ext_n = 1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); step(1);
    // R1 reset state
    chk("R1 chip_rst", chip_rst, 1); chk("R1 to", flag_to, 1); chk("R1 pd", flag_pd, 1);
    chk("R1 bor", flag_bor, 0); chk("R1 cause", cause, 0); chk("R1 wake", wake, 0);
    por_n = 1; count_rst(n);
    chk("R2 por release length", n, 25);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      v = VEC[i];
      do_por();
      if (v[11]) begin slp = 1; pulse_wdt(); step(1); slp = 0; end
      bcfg = v[7]; bsw = 0; slp = v[8];
      step(1);
      saw_rst = 0; saw_wake = 0;
      case (v[10:9])
        2'd0: pulse_wdt();
        2'd1: pulse_bod();
        default: pin_low(6);
      endcase
      step(8); slp = 0; step(40);
      chk("R7/R8/R9 vector reset", saw_rst, v[6]);
      chk("R7/R8/R9 vector to", flag_to, v[5]);
      chk("R8/R9 vector pd", flag_pd, v[4]);
      chk("R10 vector cause", cause, v[3:1]);
      chk("R6 vector bor", flag_bor, v[0]);
      if (v[10:9] == 2'd0 && v[8]) chk("R8 wake pulse", saw_wake, 1);
      bcfg = 1;
    end

    // R2 brown-out release length and R6 mid-sequence restart
    do_por();
    pulse_bod(); count_rst(n); chk("R2 bod release length", n, 25);
    pulse_bod(); step(19); pulse_bod(); count_rst(n); chk("R6 restart mid-sequence", n, 25);

    // R3 stalled tick
    lf_tick = 0; pulse_bod(); step(100);
    chk("R3 no tick holds reset", chip_rst, 1);
    lf_tick = 1; count_rst(n); chk("R3 remaining length", n, 24);

    // R4 delay enables
    pw_en = 0; pulse_bod(); count_rst(n); chk("R4 power-up skipped", n, 9);
    ost_en = 0; pulse_bod(); count_rst(n); chk("R4 both skipped", n, 1);
    pw_en = 1; pulse_bod(); count_rst(n); chk("R4 osc skipped", n, 17);
    ost_en = 1;

    // R5 glitch filter
    do_por();
    saw_rst = 0; pin_low(3); step(10);
    chk("R5 short pulse ignored", saw_rst, 0); chk("R5 cause unchanged", cause, 0);
    saw_rst = 0; pin_low(4); step(10);
    chk("R5 four samples accepted", saw_rst, 1); chk("R5 cause pin", cause, 4);
    count_rst(n);
    pin_low(20); chk("R5 held low keeps reset", chip_rst, 1);
    count_rst(n); chk("R5 release after pin high", n, 28);

    // R7 watchdog ignored in reset
    do_por();
    pulse_bod(); step(3); pulse_wdt(); step(2);
    chk("R7 wdt ignored in reset to", flag_to, 1); chk("R7 wdt ignored cause", cause, 3);
    count_rst(n);

    // R10 priority bod over wdt
    bod = 1; wdt = 1; step(1); bod = 0; wdt = 0;
    chk("R10 priority cause", cause, 3); chk("R10 priority to", flag_to, 1);
    count_rst(n);

    // R6 software enable
    bcfg = 0; bsw = 1; do_por(); saw_rst = 0; pulse_bod(); step(2);
    chk("R6 sw enable", saw_rst, 1); chk("R6 sw bor", flag_bor, 1);
    bcfg = 1; bsw = 0;

    // R11 power-on clears brown-out flag
    do_por(); chk("R11 bor cleared", flag_bor, 0); chk("R11 cause", cause, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule